// File: doc/BRIEF.md
# PCI Target Address Decoder

This block sits behind the bus interface of a PCI target. In the address phase it captures the AD bus and the command nibble. It then decides whether the transaction belongs to this agent in one of three spaces: memory, I/O or configuration. The result stays registered until the next address phase. The block does not drive bus-response timing and holds no register file. It only tells the rest of the target what was addressed.

For memory transactions it supplies a double-word address for every data beat. The address advances each time a transfer completes. The burst order comes from the low two address bits. It is linear, or for reads it can wrap inside a cache line, starting at the critical word. For I/O transactions it checks every enabled byte lane against the I/O window. It requests a target-abort when any enabled lane falls outside that window. For configuration accesses it reports the register index.

Top module: `pci_tgt_addr_dec`

## Requirements
- R1: After reset, `claim` is 0, `space` is 0 (none), `cfg_index` is 0, `burst_dw` is 0 and `abort_req` is 0.
- R2: A configuration access is claimed only in this case: the command is 1010 or 1011, `idsel` is high in the address phase, and AD[1:0] is 00. The result is `space` = 3. In every other case a configuration command leaves `claim` at 0 and `space` at 0.
- R3: On a claimed configuration access, `cfg_index` equals AD[7:2] of the address phase.
- R4: A memory command is claimed with `space` = 1 when `mem_base` <= {AD[31:2],00} <= `mem_limit`. The memory commands are 0110, 0111, 1100, 1110 and 1111. Both bounds are inclusive.
- R5: On a memory claim, `burst_dw` loads AD[31:2]. In linear order it increments by one for each cycle in which `xfer_done` is high.
- R6: A memory read with AD[1:0] = 10 uses wrap order. The read commands are 0110, 1100 and 1110. The low log2(LINE_DW) bits of `burst_dw` count up modulo LINE_DW, starting at the critical word. The upper bits are held.
- R7: Memory accesses with AD[1:0] of 01 or 11 use linear order. So do memory writes with AD[1:0] = 10.
- R8: An I/O command is claimed with `space` = 2 when `io_base` <= AD[31:0] <= `io_limit`, using the full byte address. The I/O commands are 0010 and 0011.
- R9: While an I/O access is claimed and no address phase is in progress, `abort_req` is high in the same cycle if any active-low byte enable `cbe_n[i]` is 0 for a lane whose address {A[31:2],i} lies outside [`io_base`,`io_limit`]. Otherwise it is low.
- R10: `xfer_done` has no effect on `burst_dw` unless the current claim is in memory space.
- R11: `claim`, `space` and `cfg_index` change only at an address phase. An unclaimed address phase clears `claim` and `space` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ad | input | 32 | Multiplexed address/data bus |
| cbe_n | input | 4 | Command in the address phase, active-low byte enables afterwards |
| idsel | input | 1 | Configuration select for this agent |
| addr_phase | input | 1 | High in the address-phase cycle |
| xfer_done | input | 1 | High in each cycle a data beat completes |
| mem_base | input | 32 | Lowest byte address of the memory window |
| mem_limit | input | 32 | Highest byte address of the memory window |
| io_base | input | 32 | Lowest byte address of the I/O window |
| io_limit | input | 32 | Highest byte address of the I/O window |
| claim | output | 1 | This agent owns the current transaction |
| space | output | 2 | 0 none, 1 memory, 2 I/O, 3 configuration |
| cfg_index | output | 6 | Configuration double-word register index |
| burst_dw | output | 30 | Double-word address of the current beat |
| abort_req | output | 1 | Target-abort request for a partly out-of-range I/O access |

## Verification
The bench sweeps every command against every IDSEL level and every low-bit pattern, with the address inside, at the edge of, or outside each window. A decoder that ignored IDSEL or the low bits would claim stray configuration cycles. An off-by-one window compare would lose or steal the first or last double-word. Bursts are run from every critical-word offset. A counter that carried into the upper bits, or wrapped on writes or odd low bits, would produce the wrong address at the line boundary. All sixteen byte-enable patterns are applied at both ends of the I/O window. A lane check that tested only the start byte would miss aborts for lanes past the limit.

// File: rtl/pcitd_pkg.sv
// Package: shared types and command classification for the PCI target
// address decoder. Assumes the standard PCI command nibble coding.
package pcitd_pkg;

    typedef enum logic [1:0] {
        SP_NONE = 2'd0,
        SP_MEM  = 2'd1,
        SP_IO   = 2'd2,
        SP_CFG  = 2'd3
    } space_e;

    // Memory commands: read, write, read multiple, read line, write+invalidate
    function automatic logic cmd_is_mem(input logic [3:0] c);
        return (c == 4'h6) || (c == 4'h7) || (c == 4'hC) ||
               (c == 4'hE) || (c == 4'hF);
    endfunction

    // Memory read flavours, the only ones allowed to use wrap order
    function automatic logic cmd_is_mem_rd(input logic [3:0] c);
        return (c == 4'h6) || (c == 4'hC) || (c == 4'hE);
    endfunction

    function automatic logic cmd_is_io(input logic [3:0] c);
        return (c == 4'h2) || (c == 4'h3);
    endfunction

    function automatic logic cmd_is_cfg(input logic [3:0] c);
        return c[3:1] == 3'b101;
    endfunction

endpackage

// File: rtl/pcitd_space_decode.sv
// Module: pcitd_space_decode
// Combinational claim decision for one address phase. It classifies the
// command, compares the address with the memory and I/O windows (inclusive
// bounds) and flags wrap order for memory reads with low bits 10.
// Assumes the windows are stable while an address phase is decoded.
module pcitd_space_decode
    import pcitd_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] ad,
    input  logic [3:0]    cmd,
    input  logic          idsel,
    input  logic [AW-1:0] mem_base,
    input  logic [AW-1:0] mem_limit,
    input  logic [AW-1:0] io_base,
    input  logic [AW-1:0] io_limit,
    output space_e        hit,
    output logic          wrap_req
);
    logic [AW-1:0] dw_byte;
    logic          mem_in, io_in;

    // Window compares: memory on the double-word address, I/O on the byte address
    always_comb begin
        dw_byte = {ad[AW-1:2], 2'b00};
        mem_in  = (dw_byte >= mem_base) && (dw_byte <= mem_limit);
        io_in   = (ad >= io_base) && (ad <= io_limit);
    end

    // Space selection by command class
    always_comb begin
        hit = SP_NONE;
        if (cmd_is_cfg(cmd)) begin
            if (idsel && (ad[1:0] == 2'b00)) hit = SP_CFG;
        end else if (cmd_is_mem(cmd)) begin
            if (mem_in) hit = SP_MEM;
        end else if (cmd_is_io(cmd)) begin
            if (io_in) hit = SP_IO;
        end
    end

    // Wrap order only for memory reads that ask for cache-line wrap
    always_comb wrap_req = cmd_is_mem_rd(cmd) && (ad[1:0] == 2'b10);

endmodule

// File: rtl/pcitd_burst_ctr.sv
// Module: pcitd_burst_ctr
// Double-word burst address generator. It loads a start address, then
// advances once per completed beat, either linearly or wrapping within
// a cache line of LINE_DW double-words.
// Assumes LINE_DW is a power of two and at least 2.
module pcitd_burst_ctr #(
    parameter int DW_W    = 30,
    parameter int LINE_DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [DW_W-1:0] start,
    input  logic            wrap_in,
    input  logic            step,
    output logic [DW_W-1:0] dw_addr
);
    localparam int LB = $clog2(LINE_DW);

    logic            wrap_q;
    logic [DW_W-1:0] nxt;

    // Next beat address in the selected order
    always_comb begin
        nxt = dw_addr + DW_W'(1);
        if (wrap_q) nxt = {dw_addr[DW_W-1:LB], dw_addr[LB-1:0] + LB'(1)};
    end

    // Address and order register; load has priority over step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dw_addr <= '0;
            wrap_q  <= 1'b0;
        end else if (load) begin
            dw_addr <= start;
            wrap_q  <= wrap_in;
        end else if (step) begin
            dw_addr <= nxt;
        end
    end

    a_r5_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !wrap_q) |=> (dw_addr == $past(dw_addr) + DW_W'(1)));

    a_r6_wrap_keeps_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && wrap_q) |=> (dw_addr[DW_W-1:LB] == $past(dw_addr[DW_W-1:LB])));

    a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(dw_addr));

endmodule

// File: rtl/pcitd_io_lane_chk.sv
// Module: pcitd_io_lane_chk
// Per-byte-lane range check for an I/O access. It flags any enabled lane
// (active-low enable) whose byte address lies outside the window.
// Assumes a 4-lane, 32-bit data path.
module pcitd_io_lane_chk #(
    parameter int AW    = 32,
    parameter int LANES = 4
) (
    input  logic [AW-1:0]    addr,
    input  logic [LANES-1:0] be_n,
    input  logic [AW-1:0]    lo,
    input  logic [AW-1:0]    hi,
    output logic             outside
);
    localparam int LW = $clog2(LANES);

    logic [LANES-1:0] lane_bad;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [AW-1:0] lane_addr;
        // Byte address of this lane and its out-of-window flag
        always_comb begin
            lane_addr   = {addr[AW-1:LW], LW'(i)};
            lane_bad[i] = !be_n[i] && ((lane_addr < lo) || (lane_addr > hi));
        end
    end

    // Any bad lane spoils the whole access
    always_comb outside = |lane_bad;

endmodule

// File: rtl/pci_tgt_addr_dec.sv
// Module: pci_tgt_addr_dec (top)
// Captures the address phase, registers the claim result and space,
// drives the configuration index and the burst double-word address, and
// raises a target-abort request for partly out-of-range I/O accesses.
// Assumes addr_phase marks exactly the address-phase cycle and that
// xfer_done only marks data-phase cycles.
module pci_tgt_addr_dec
    import pcitd_pkg::*;
#(
    parameter int LINE_DW = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] ad,
    input  logic [3:0]  cbe_n,
    input  logic        idsel,
    input  logic        addr_phase,
    input  logic        xfer_done,
    input  logic [31:0] mem_base,
    input  logic [31:0] mem_limit,
    input  logic [31:0] io_base,
    input  logic [31:0] io_limit,
    output logic        claim,
    output logic [1:0]  space,
    output logic [5:0]  cfg_index,
    output logic [29:0] burst_dw,
    output logic        abort_req
);
    localparam int AW   = 32;
    localparam int DW_W = AW - 2;

    space_e        hit, space_q;
    logic          wrap_req;
    logic [AW-1:0] io_addr_q;
    logic          io_outside;
    logic          burst_load, burst_step;

    pcitd_space_decode #(.AW(AW)) u_dec (
        .ad        (ad),
        .cmd       (cbe_n),
        .idsel     (idsel),
        .mem_base  (mem_base),
        .mem_limit (mem_limit),
        .io_base   (io_base),
        .io_limit  (io_limit),
        .hit       (hit),
        .wrap_req  (wrap_req)
    );

    // Registered claim, space, configuration index and I/O start address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            claim     <= 1'b0;
            space_q   <= SP_NONE;
            cfg_index <= '0;
            io_addr_q <= '0;
        end else if (addr_phase) begin
            claim     <= (hit != SP_NONE);
            space_q   <= hit;
            cfg_index <= (hit == SP_CFG) ? ad[7:2] : 6'd0;
            io_addr_q <= ad;
        end
    end

    // Burst counter control: load on a memory claim, step on memory beats
    always_comb begin
        burst_load = addr_phase && (hit == SP_MEM);
        burst_step = xfer_done && !addr_phase && claim && (space_q == SP_MEM);
    end

    pcitd_burst_ctr #(.DW_W(DW_W), .LINE_DW(LINE_DW)) u_burst (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (burst_load),
        .start   (ad[AW-1:2]),
        .wrap_in (wrap_req),
        .step    (burst_step),
        .dw_addr (burst_dw)
    );

    pcitd_io_lane_chk #(.AW(AW), .LANES(4)) u_io (
        .addr    (io_addr_q),
        .be_n    (cbe_n),
        .lo      (io_base),
        .hi      (io_limit),
        .outside (io_outside)
    );

    // Abort request only in the data phase of a claimed I/O access
    always_comb begin
        space     = space_q;
        abort_req = claim && (space_q == SP_IO) && !addr_phase && io_outside;
    end

    a_r2_cfg_needs_idsel: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_phase && cmd_is_cfg(cbe_n) && !idsel) |=> !claim);

    a_r9_abort_only_io: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |-> (claim && space_q == SP_IO));

    a_r11_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_phase |=> ($stable(space_q) && $stable(claim) && $stable(cfg_index)));

    a_r11_claim_space_agree: assert property (@(posedge clk) disable iff (!rst_n)
        claim == (space_q != SP_NONE));

endmodule

// File: tb/pci_tgt_addr_dec_bench.sv
module pci_tgt_addr_dec_bench;
    localparam int LINE_DW = 8;
    localparam int LB      = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ad = '0;
    logic [3:0]  cbe_n = 4'hF;
    logic        idsel = 1'b0;
    logic        addr_phase = 1'b0;
    logic        xfer_done = 1'b0;
    logic [31:0] mem_base = 32'h1000_0000;
    logic [31:0] mem_limit = 32'h1000_0FFF;
    logic [31:0] io_base = 32'h0000_2000;
    logic [31:0] io_limit = 32'h0000_20FF;
    logic        claim;
    logic [1:0]  space;
    logic [5:0]  cfg_index;
    logic [29:0] burst_dw;
    logic        abort_req;

    int compared = 0;
    int mismatched = 0;

    always #2.5 clk = ~clk;

    pci_tgt_addr_dec #(.LINE_DW(LINE_DW)) u_pci_tgt_addr_dec (
        .clk(clk), .rst_n(rst_n), .ad(ad), .cbe_n(cbe_n), .idsel(idsel),
        .addr_phase(addr_phase), .xfer_done(xfer_done),
        .mem_base(mem_base), .mem_limit(mem_limit),
        .io_base(io_base), .io_limit(io_limit),
        .claim(claim), .space(space), .cfg_index(cfg_index),
        .burst_dw(burst_dw), .abort_req(abort_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic is_mem(input logic [3:0] c);
        return c == 4'h6 || c == 4'h7 || c == 4'hC || c == 4'hE || c == 4'hF;
    endfunction
    function automatic logic is_rd(input logic [3:0] c);
        return c == 4'h6 || c == 4'hC || c == 4'hE;
    endfunction

    // Reference space from the requirements (R2, R4, R8)
    function automatic logic [1:0] ref_space(input logic [31:0] a, input logic [3:0] c,
                                             input logic sel);
        logic [31:0] dwb;
        dwb = {a[31:2], 2'b00};
        if (c == 4'hA || c == 4'hB) return (sel && a[1:0] == 2'b00) ? 2'd3 : 2'd0;
        if (is_mem(c)) return (dwb >= mem_base && dwb <= mem_limit) ? 2'd1 : 2'd0;
        if (c == 4'h2 || c == 4'h3) return (a >= io_base && a <= io_limit) ? 2'd2 : 2'd0;
        return 2'd0;
    endfunction

    // Address phase in one cycle; outputs are sampled after the capturing edge
    task automatic addr_cycle(input logic [31:0] a, input logic [3:0] c,
                              input logic sel, input logic [3:0] be);
        @(negedge clk);
        ad = a; cbe_n = c; idsel = sel; addr_phase = 1'b1;
        @(negedge clk);
        addr_phase = 1'b0; cbe_n = be; idsel = 1'b0; ad = 32'hDEAD_BEEF;
        #1;
    endtask

    task automatic beat();
        @(negedge clk);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        check("R1 claim", 32'(claim), 0);
        check("R1 space", 32'(space), 0);
        check("R1 cfg_index", 32'(cfg_index), 0);
        check("R1 burst_dw", 32'(burst_dw), 0);
        check("R1 abort_req", 32'(abort_req), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 R3 R4 R8 R11: sweep commands, idsel, low bits and regions
        for (int c = 0; c < 16; c++) begin
            for (int s = 0; s < 2; s++) begin
                for (int lo = 0; lo < 4; lo++) begin
                    for (int rg = 0; rg < 3; rg++) begin
                        logic [31:0] a;
                        logic [1:0]  es;
                        a = (rg == 0) ? 32'h1000_0000 : (rg == 1) ? 32'h0000_2000 : 32'h3000_0000;
                        a = a + 32'(c * 16) + 32'(s * 4) + 32'(lo);
                        es = ref_space(a, 4'(c), 1'(s));
                        addr_cycle(a, 4'(c), 1'(s), 4'hF);
                        check("R2/R4/R8 space", 32'(space), 32'(es));
                        check("R11 claim", 32'(claim), 32'(es != 2'd0));
                        if (es == 2'd3) check("R3 cfg_index", 32'(cfg_index), 32'(a[7:2]));
                    end
                end
            end
        end

        // R4 inclusive memory window edges
        addr_cycle(32'h1000_0FFC, 4'h7, 1'b0, 4'hF); check("R4 at limit", 32'(space), 1);
        addr_cycle(32'h1000_1000, 4'h7, 1'b0, 4'hF); check("R4 past limit", 32'(space), 0);
        addr_cycle(32'h0FFF_FFFC, 4'h6, 1'b0, 4'hF); check("R4 below base", 32'(space), 0);
        addr_cycle(32'h1000_0000, 4'h6, 1'b0, 4'hF); check("R4 at base", 32'(space), 1);
        // R8 inclusive I/O window edges on the byte address
        addr_cycle(32'h0000_20FF, 4'h2, 1'b0, 4'hF); check("R8 at limit", 32'(space), 2);
        addr_cycle(32'h0000_2100, 4'h2, 1'b0, 4'hF); check("R8 past limit", 32'(space), 0);
        addr_cycle(32'h0000_1FFF, 4'h3, 1'b0, 4'hF); check("R8 below base", 32'(space), 0);

        // R5 R6 R7: bursts from every critical word, in all order modes
        for (int m = 0; m < 5; m++) begin
            for (int off = 0; off < LINE_DW; off++) begin
                logic [3:0]  c;
                logic [1:0]  lo;
                logic        wrp;
                logic [29:0] exp;
                logic [31:0] a;
                c  = (m == 2) ? 4'h7 : (m == 4) ? 4'hE : 4'h6;
                lo = (m == 0) ? 2'b00 : (m == 3) ? 2'b01 : 2'b10;
                if (m == 4) lo = 2'b11;
                wrp = is_rd(c) && lo == 2'b10;
                a   = 32'h1000_0200 + 32'(off * 4) + 32'(lo);
                exp = a[31:2];
                addr_cycle(a, c, 1'b0, 4'h0);
                check("R5 start", 32'(burst_dw), 32'(exp));
                for (int b = 0; b < 10; b++) begin
                    beat();
                    if (wrp) exp = {exp[29:LB], exp[LB-1:0] + 3'd1};
                    else     exp = exp + 30'd1;
                    if (wrp) check("R6 wrap beat", 32'(burst_dw), 32'(exp));
                    else     check("R5/R7 linear beat", 32'(burst_dw), 32'(exp));
                end
            end
        end

        // R10: beats during I/O and unclaimed transactions leave burst_dw alone
        addr_cycle(32'h1000_0040, 4'h6, 1'b0, 4'h0);
        addr_cycle(32'h0000_2010, 4'h2, 1'b0, 4'h0);
        beat(); beat();
        check("R10 io beat", 32'(burst_dw), 32'h0400_0010);
        addr_cycle(32'h5000_0000, 4'h6, 1'b0, 4'h0);
        beat();
        check("R10 unclaimed beat", 32'(burst_dw), 32'h0400_0010);

        // R9: every byte-enable pattern at both ends of a narrowed I/O window
        io_base = 32'h0000_2001;
        io_limit = 32'h0000_2106;
        for (int e = 0; e < 2; e++) begin
            for (int be = 0; be < 16; be++) begin
                logic [31:0] a;
                logic        exp;
                a = (e == 0) ? 32'h0000_2001 : 32'h0000_2104;
                exp = 1'b0;
                for (int l = 0; l < 4; l++) begin
                    logic [31:0] la;
                    la = {a[31:2], 2'(l)};
                    if (!be[l] && (la < io_base || la > io_limit)) exp = 1'b1;
                end
                addr_cycle(a, 4'h3, 1'b0, 4'(be));
                check("R9 abort", 32'(abort_req), 32'(exp));
            end
        end
        // R9: no abort on a memory claim even with all lanes enabled
        addr_cycle(32'h1000_0000, 4'h7, 1'b0, 4'h0);
        check("R9 no abort on memory", 32'(abort_req), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule